// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer for a system whose software must prove it is still alive. The software reaches it through a 16-bit register write port. A 32-bit counter advances on a tick that is chosen from one of two tick-enable inputs: one comes from the bus clock and one from a low-power oscillator. A small prescaler divides that tick. If the counter passes the programmed timeout, the block raises a one-cycle reset request. With the interrupt-before-reset mode on, it raises an interrupt first and the reset request comes a fixed delay later.

Both configuration and servicing are protected by two-word keys. The control, timeout, window and prescaler registers accept writes only for a short period that opens after a correct unlock pair. The counter restarts only when a correct refresh pair completes. A wrong word, a word out of order, a late second unlock word, or an early refresh in window mode is treated as a fault: the block requests a reset and does not ignore the write. After the first configuration period closes, the block can be reopened only if the allow-update control bit was set.

The write port has no back-pressure. A write presented with `wr_valid` high is taken on that clock edge. Debug, stop and wait mode inputs freeze the count unless the matching control bit allows counting in that mode.

Top module: `wdt_keyseq`

## Requirements
- R1: After reset `irq` and `rst_req` are low, the watchdog is disabled, and no reset request appears while it stays disabled.
- R2: The unlock pair is 0xC520 followed by 0xD928, both written to address 6. The second word is accepted when it arrives 1 to 20 cycles after the first. If it has not arrived by the 20th cycle, or if any unlock word is wrong or out of order, `rst_req` is raised.
- R3: Writes to control (address 0), timeout high half (address 2), timeout low half (address 3), window (address 4) and prescale (address 5) take effect only during the 256 cycles after a completed unlock. At any other time they are ignored.
- R4: Once the first configuration period has closed, a new unlock word causes a reset request unless control bit 4 (allow update) is set. With that bit set, the unlock works as in R2.
- R5: The refresh pair is 0xA602 followed by 0xB480, both written to address 7. Only the completed pair restarts the count from zero. A wrong or out-of-order refresh word raises `rst_req`.
- R6: With control bit 0 (enable) set, the counter advances once per divided tick, where the selected tick is divided by (prescale + 1). On the (timeout + 1)-th divided tick the block times out. Without interrupt mode, `rst_req` follows on that same clock edge.
- R7: Control bit 1 selects the tick source: 0 selects `bus_tick` and 1 selects `lp_tick`.
- R8: With control bit 2 set, a timeout sets the interrupt flag (status bit 0, shown on `irq`). `rst_req` then follows exactly 128 cycles later.
- R9: Writing 1 to bit 0 at the status address (address 1) clears the interrupt flag. Writing 0 leaves it set.
- R10: With control bit 3 (window mode) set, a refresh pair that completes while the count is below the window value raises `rst_req`. A refresh pair that completes at or above the window value is accepted.
- R11: While `dbg_mode`, `stop_mode` or `wait_mode` is high and the matching control bit (5, 6 or 7) is clear, the count is frozen.
- R12: `rst_req` is a single-cycle pulse and is issued at most once between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Tick enable derived from the bus clock |
| lp_tick | input | 1 | Tick enable derived from the low-power oscillator |
| dbg_mode | input | 1 | Debug halt is active |
| stop_mode | input | 1 | Stop low-power mode is active |
| wait_mode | input | 1 | Wait low-power mode is active |
| wr_valid | input | 1 | Register write strobe, taken on this edge |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| irq | output | 1 | Watchdog interrupt (status flag) |
| rst_req | output | 1 | One-cycle reset request to the chip reset controller |

## Verification
A key checker left in a wrong state shows up as a reset request one edge after the next unlock or refresh write. It can also show up 20 cycles after a lone first unlock word, or as configuration writes that are taken or dropped when they should not be. A counter or prescaler that is off by one shifts the edge of `rst_req` by a whole divided tick. For that reason the timeout distance is measured exactly, in cycles, from the write that enables the watchdog or from the last refresh. A pre-reset delay that is wrong moves `rst_req` relative to the rising edge of `irq`, and a flag that is stuck shows up at the next status write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOV_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TOV_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WIN     = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRESC   = 3'd5;
  localparam logic [ADDR_W-1:0] A_UNLOCK  = 3'd6;
  localparam logic [ADDR_W-1:0] A_REFRESH = 3'd7;

  localparam logic [DATA_W-1:0] UNL_KEY1 = 16'hC520;
  localparam logic [DATA_W-1:0] UNL_KEY2 = 16'hD928;
  localparam logic [DATA_W-1:0] REF_KEY1 = 16'hA602;
  localparam logic [DATA_W-1:0] REF_KEY2 = 16'hB480;

  // control bit positions
  localparam int C_EN    = 0;
  localparam int C_LP    = 1;
  localparam int C_IRQ   = 2;
  localparam int C_WIN   = 3;
  localparam int C_ALLOW = 4;
  localparam int C_DBG   = 5;
  localparam int C_STOP  = 6;
  localparam int C_WAIT  = 7;
  localparam int CTRL_W  = 8;

  typedef enum logic [1:0] {U_IDLE, U_WAIT2, U_OPEN} unl_state_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
#(
  parameter int LIMIT       = 20,
  parameter int OPEN_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              allow,
  output logic              cfg_open,
  output logic              viol
);
  localparam int DL_W = $clog2(LIMIT + 1);
  localparam int OC_W = $clog2(OPEN_CYCLES);
  localparam logic [DL_W-1:0] DL_LAST = DL_W'(LIMIT - 1);
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OPEN_CYCLES - 1);

  unl_state_t      st_q;
  logic [DL_W-1:0] dl_q;
  logic [OC_W-1:0] oc_q;
  logic            sealed_q;

  always_comb begin
    viol = 1'b0;
    case (st_q)
      U_WAIT2: viol = wr ? (data != UNL_KEY2) : (dl_q == DL_LAST);
      default: viol = wr && ((sealed_q && !allow) || (data != UNL_KEY1));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= U_IDLE;
      dl_q     <= '0;
      oc_q     <= '0;
      sealed_q <= 1'b0;
    end else begin
      case (st_q)
        U_WAIT2: begin
          if (viol) begin
            st_q <= U_IDLE;
          end else if (wr) begin
            st_q <= U_OPEN;
            oc_q <= '0;
          end else begin
            dl_q <= dl_q + 1'b1;
          end
        end
        U_OPEN: begin
          if (wr) begin
            st_q <= viol ? U_IDLE : U_WAIT2;
            dl_q <= '0;
          end else if (oc_q == OC_LAST) begin
            st_q     <= U_IDLE;
            sealed_q <= 1'b1;
          end else begin
            oc_q <= oc_q + 1'b1;
          end
        end
        default: begin
          if (wr && !viol) begin
            st_q <= U_WAIT2;
            dl_q <= '0;
          end
        end
      endcase
    end
  end

  assign cfg_open = (st_q == U_OPEN);
endmodule

// File: rtl/wdt_refresh.sv
module wdt_refresh
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              win_en,
  input  logic              below_win,
  output logic              ok,
  output logic              viol
);
  logic got1_q;
  logic early;

  assign early = win_en && below_win;

  always_comb begin
    ok   = 1'b0;
    viol = 1'b0;
    if (wr) begin
      if (!got1_q) begin
        viol = (data != REF_KEY1);
      end else begin
        viol = (data != REF_KEY2) || early;
        ok   = (data == REF_KEY2) && !early;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got1_q <= 1'b0;
    else if (wr) got1_q <= !got1_q && (data == REF_KEY1);
  end
endmodule

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clr,
  input  logic               sel_lp,
  input  logic               bus_tick,
  input  logic               lp_tick,
  input  logic [PRESC_W-1:0] presc,
  output logic               dtick
);
  logic               src;
  logic [PRESC_W-1:0] pcnt_q;

  assign src   = sel_lp ? lp_tick : bus_tick;
  assign dtick = run && src && (pcnt_q == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (clr || !run) pcnt_q <= '0;
    else if (src) pcnt_q <= (pcnt_q == presc) ? '0 : pcnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int PRESC_W      = 3,
  parameter int UNLOCK_LIMIT = 20,
  parameter int OPEN_CYCLES  = 256,
  parameter int IRQ_DELAY    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic              lp_tick,
  input  logic              dbg_mode,
  input  logic              stop_mode,
  input  logic              wait_mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic              rst_req
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int PD_W  = $clog2(IRQ_DELAY);
  localparam logic [PD_W-1:0] PD_LAST = PD_W'(IRQ_DELAY - 1);
  localparam int N_MODES = 3;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   tov_q;
  logic [DATA_W-1:0]  win_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               flag_q;
  logic               pre_act_q;
  logic [PD_W-1:0]    pre_cnt_q;
  logic               fired_q;
  logic               rst_req_q;

  logic cfg_open, unl_viol, ref_ok, ref_viol, dtick;
  logic run, timeout, to_take, pre_fire, rst_evt, cfg_we, below_win;

  // ---- key checkers ----
  wdt_unlock #(.LIMIT(UNLOCK_LIMIT), .OPEN_CYCLES(OPEN_CYCLES)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr_valid && wr_addr == A_UNLOCK),
    .data     (wr_data),
    .allow    (ctrl_q[C_ALLOW]),
    .cfg_open (cfg_open),
    .viol     (unl_viol)
  );

  assign below_win = cnt_q < CNT_W'(win_q);

  wdt_refresh u_refresh (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_valid && wr_addr == A_REFRESH),
    .data      (wr_data),
    .win_en    (ctrl_q[C_WIN]),
    .below_win (below_win),
    .ok        (ref_ok),
    .viol      (ref_viol)
  );

  // ---- low-power / debug freeze ----
  logic [N_MODES-1:0] mode_vec, halt_bits;
  assign mode_vec = {wait_mode, stop_mode, dbg_mode};

  for (genvar g = 0; g < N_MODES; g++) begin : g_halt
    assign halt_bits[g] = mode_vec[g] && !ctrl_q[C_DBG + g];
  end

  assign run = ctrl_q[C_EN] && !(|halt_bits);

  wdt_tick_div #(.PRESC_W(PRESC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clr      (ref_ok),
    .sel_lp   (ctrl_q[C_LP]),
    .bus_tick (bus_tick),
    .lp_tick  (lp_tick),
    .presc    (presc_q),
    .dtick    (dtick)
  );

  // ---- configuration registers ----
  assign cfg_we = wr_valid && cfg_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tov_q   <= '1;
      win_q   <= '0;
      presc_q <= '0;
    end else if (cfg_we) begin
      case (wr_addr)
        A_CTRL:   ctrl_q              <= wr_data[CTRL_W-1:0];
        A_TOV_HI: tov_q[CNT_W-1:DATA_W] <= wr_data;
        A_TOV_LO: tov_q[DATA_W-1:0]   <= wr_data;
        A_WIN:    win_q               <= wr_data;
        A_PRESC:  presc_q             <= wr_data[PRESC_W-1:0];
        default: ;
      endcase
    end
  end

  // ---- countdown ----
  assign timeout = dtick && (cnt_q >= tov_q);
  assign to_take = timeout && !pre_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!ctrl_q[C_EN] || ref_ok || timeout) cnt_q <= '0;
    else if (dtick) cnt_q <= cnt_q + 1'b1;
  end

  // ---- interrupt and pre-reset delay ----
  assign pre_fire = pre_act_q && (pre_cnt_q == PD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_act_q <= 1'b0;
      pre_cnt_q <= '0;
    end else if (to_take && ctrl_q[C_IRQ]) begin
      pre_act_q <= 1'b1;
      pre_cnt_q <= '0;
    end else if (pre_fire) begin
      pre_act_q <= 1'b0;
    end else if (pre_act_q) begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (to_take && ctrl_q[C_IRQ]) flag_q <= 1'b1;
    else if (wr_valid && wr_addr == A_STATUS && wr_data[0]) flag_q <= 1'b0;
  end

  // ---- reset request, one shot ----
  assign rst_evt = unl_viol || ref_viol || pre_fire || (to_take && !ctrl_q[C_IRQ]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      fired_q   <= 1'b0;
    end else begin
      rst_req_q <= rst_evt && !fired_q;
      fired_q   <= fired_q || rst_evt;
    end
  end

  assign irq     = flag_q;
  assign rst_req = rst_req_q;
endmodule

// File: rtl/wdt_keyseq_chk.sv
module wdt_keyseq_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              rst_req,
  input logic              fired,
  input logic              cfg_open,
  input logic              ref_ok,
  input logic [31:0]       cnt,
  input logic [DATA_W-1:0] tov_lo
);
  AST_RST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R12

  AST_BAD_UNLOCK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == A_UNLOCK && wr_data != UNL_KEY1 && wr_data != UNL_KEY2 && !fired)
    |=> rst_req); // R2

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr == A_TOV_LO && !cfg_open) |=> $stable(tov_lo)); // R3

  AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ok |=> (cnt == '0)); // R5

  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_valid && wr_addr == A_STATUS && wr_data[0])); // R9
endmodule

bind wdt_keyseq wdt_keyseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .irq      (irq),
  .rst_req  (rst_req),
  .fired    (fired_q),
  .cfg_open (cfg_open),
  .ref_ok   (ref_ok),
  .cnt      (cnt_q),
  .tov_lo   (tov_q[15:0])
);

// File: tb/wdt_keyseq_tb_top.sv
`timescale 1ns/1ps
module wdt_keyseq_tb_top;
  import wdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_tick = 1'b1;
  logic        lp_tick;
  logic        dbg_mode = 1'b0, stop_mode = 1'b0, wait_mode = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        irq, rst_req;

  always #10 clk = ~clk;   // 50 MHz

  wdt_keyseq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .lp_tick(lp_tick),
    .dbg_mode(dbg_mode), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .rst_req(rst_req)
  );

  // low-power tick: one pulse every 4 cycles
  logic [1:0] lp_div = '0;
  always @(negedge clk) lp_div <= lp_div + 1'b1;
  assign lp_tick = (lp_div == 2'd0);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitors, sampled shortly after each edge
  bit rst_seen, irq_seen;
  int rst_cyc, irq_cyc, rst_cnt;
  always @(posedge clk) begin
    #2;
    if (rst_req) begin
      rst_cnt++;
      if (!rst_seen) begin rst_seen = 1; rst_cyc = cyc; end
    end
    if (irq && !irq_seen) begin irq_seen = 1; irq_cyc = cyc; end
  end

  int checks = 0, fails = 0;
  int c_en;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_seen = 0; irq_seen = 0; rst_cnt = 0;
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic unlock();
    wr(A_UNLOCK, UNL_KEY1);
    wr(A_UNLOCK, UNL_KEY2);
  endtask

  task automatic refresh();
    wr(A_REFRESH, REF_KEY1);
    wr(A_REFRESH, REF_KEY2);
  endtask

  task automatic cfg(input logic [15:0] ctrl, input logic [31:0] tov,
                     input logic [15:0] presc, input logic [15:0] win);
    unlock();
    wr(A_PRESC, presc);
    wr(A_WIN, win);
    wr(A_TOV_HI, tov[31:16]);
    wr(A_TOV_LO, tov[15:0]);
    wr(A_CTRL, ctrl);
    c_en = cyc;
  endtask

  task automatic wait_rst(input int max);
    for (int i = 0; i < max && !rst_seen; i++) @(negedge clk);
  endtask

  // {addr, word1, word2, expect reset}
  localparam logic [35:0] VEC [8] = '{
    {3'd7, 16'hA602, 16'hB480, 1'b0},
    {3'd7, 16'hB480, 16'hA602, 1'b1},
    {3'd7, 16'hA602, 16'hA602, 1'b1},
    {3'd7, 16'h1234, 16'hB480, 1'b1},
    {3'd6, 16'hC520, 16'hD928, 1'b0},
    {3'd6, 16'hD928, 16'hC520, 1'b1},
    {3'd6, 16'hC520, 16'hC520, 1'b1},
    {3'd6, 16'h0000, 16'hD928, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state and disabled behaviour
    chk("R1 irq after reset", irq, 0);
    chk("R1 rst_req after reset", rst_req, 0);
    idle(300);
    chk("R1 no reset while disabled", rst_seen, 0);

    // R2 / R5: key pair table
    for (int i = 0; i < 8; i++) begin
      logic [35:0] v;
      v = VEC[i];
      do_reset();
      wr(v[35:33], v[32:17]);
      wr(v[35:33], v[16:1]);
      idle(3);
      chk((v[35:33] == A_UNLOCK) ? "R2 unlock pair" : "R5 refresh pair", rst_seen, v[0]);
    end

    // R6: timeout distance, no prescale
    do_reset();
    cfg(16'h0001, 32'd40, 16'd0, 16'd0);
    wait_rst(500);
    chk("R6 timeout distance presc0", rst_cyc - c_en, 41);
    chk("R6 no irq without irq mode", irq_seen, 0);

    // R6: prescale by 3
    do_reset();
    cfg(16'h0001, 32'd10, 16'd2, 16'd0);
    wait_rst(500);
    chk("R6 timeout distance presc2", rst_cyc - c_en, 33);

    // R7: low-power source, bus tick silent
    do_reset();
    bus_tick = 1'b0;
    cfg(16'h0003, 32'd9, 16'd0, 16'd0);
    wait_rst(500);
    chk_rng("R7 low-power source timeout", rst_cyc - c_en, 37, 43);
    bus_tick = 1'b1;

    // R8 / R9: interrupt before reset and flag clearing
    do_reset();
    cfg(16'h0005, 32'd200, 16'd0, 16'd0);
    for (int i = 0; i < 500 && !irq_seen; i++) @(negedge clk);
    chk("R8 irq after timeout", irq_cyc - c_en, 201);
    chk("R8 no reset before delay", rst_seen, 0);
    wr(A_STATUS, 16'h0000);
    chk("R9 write 0 keeps flag", irq, 1);
    wr(A_STATUS, 16'h0001);
    chk("R9 write 1 clears flag", irq, 0);
    wait_rst(300);
    chk("R8 reset delay after irq", rst_cyc - irq_cyc, 128);

    // R5: completed refresh restarts count
    do_reset();
    cfg(16'h0001, 32'd100, 16'd0, 16'd0);
    idle(60);
    refresh();
    c_en = cyc;
    chk("R5 refresh no reset", rst_seen, 0);
    wait_rst(500);
    chk("R5 timeout measured from refresh", rst_cyc - c_en, 101);

    // R10: window mode
    do_reset();
    cfg(16'h0009, 32'd1000, 16'd0, 16'd100);
    idle(20);
    refresh();
    idle(2);
    chk("R10 early refresh resets", rst_seen, 1);
    do_reset();
    cfg(16'h0009, 32'd1000, 16'd0, 16'd100);
    idle(150);
    refresh();
    idle(5);
    chk("R10 late refresh accepted", rst_seen, 0);

    // R2: unlock deadline boundary
    do_reset();
    wr(A_UNLOCK, UNL_KEY1);
    idle(19);
    chk("R2 no reset before deadline", rst_seen, 0);
    wr(A_UNLOCK, UNL_KEY2);
    wr(A_TOV_HI, 16'd0);
    wr(A_TOV_LO, 16'd5);
    wr(A_CTRL, 16'h0001);
    c_en = cyc;
    wait_rst(100);
    chk("R2 second word at cycle 20 opens config", rst_cyc - c_en, 6);
    do_reset();
    wr(A_UNLOCK, UNL_KEY1);
    idle(20);
    chk("R2 missing second word resets", rst_seen, 1);

    // R3: writes without unlock and after window are ignored
    do_reset();
    wr(A_CTRL, 16'h0001);
    idle(50);
    chk("R3 locked ctrl write ignored", rst_seen, 0);
    do_reset();
    cfg(16'h0001, 32'd300, 16'd0, 16'd0);
    idle(270);
    wr(A_TOV_LO, 16'd5);
    wait_rst(200);
    chk("R3 late timeout write ignored", rst_cyc - c_en, 301);

    // R4: resealed unlock
    do_reset();
    unlock();
    idle(300);
    wr(A_UNLOCK, UNL_KEY1);
    idle(2);
    chk("R4 unlock after seal resets", rst_seen, 1);
    do_reset();
    unlock();
    wr(A_CTRL, 16'h0010);
    idle(300);
    unlock();
    wr(A_TOV_HI, 16'd0);
    wr(A_TOV_LO, 16'd20);
    wr(A_CTRL, 16'h0011);
    c_en = cyc;
    wait_rst(200);
    chk("R4 allow-update reunlock works", rst_cyc - c_en, 21);

    // R11: debug freeze
    do_reset();
    dbg_mode = 1'b1;
    cfg(16'h0001, 32'd30, 16'd0, 16'd0);
    idle(200);
    chk("R11 frozen in debug", rst_seen, 0);
    dbg_mode = 1'b0;
    c_en = cyc;
    wait_rst(100);
    chk("R11 count resumes after debug", rst_cyc - c_en, 31);
    do_reset();
    dbg_mode = 1'b1;
    cfg(16'h0021, 32'd30, 16'd0, 16'd0);
    wait_rst(100);
    chk("R11 counts in debug when allowed", rst_cyc - c_en, 31);
    dbg_mode = 1'b0;

    // R12: single pulse despite repeated faults
    do_reset();
    wr(A_REFRESH, 16'h0000);
    wr(A_REFRESH, 16'h0000);
    wr(A_UNLOCK, 16'h0000);
    idle(5);
    chk("R12 one pulse per reset", rst_cnt, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule